// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a memory device. A test clock and a mode-select input drive a 16-state controller. The controller decides which of three shift paths sits between the serial data input and the serial data output: the instruction register, a one-bit bypass stage, or a boundary-scan chain that samples the device's I/O ring.

The test port only observes the I/O ring. It has no path back into the functional memory logic. Resetting it or scanning through it therefore cannot disturb normal memory traffic.

An asynchronous power-up reset puts the port in Test-Logic-Reset. Holding mode-select high for five test-clock rising edges does the same from any state.

The instruction is three bits wide. Code 100 selects the boundary chain for sampling and preloading. Code 101 is reserved and is treated as bypass, as are all other codes.

The boundary chain captures the ring on Capture-DR. It then shifts the captured data out while new preload data shifts in behind it. Chain positions that belong to unconnected balls always capture 0. One designated position always captures 1.

Top module: `bscan_tap`

## Requirements
- R1: Five consecutive rising edges of `tck_i` with `tms_i` high bring the controller to Test-Logic-Reset from any state. Test-Logic-Reset sets the active instruction to 111 (bypass).
- R2: While `rst_ni` is low the controller is held in Test-Logic-Reset, the active instruction is 111 and `tdo_en_o` is 0.
- R3: Capture-IR loads 3'b001 into the instruction shift register (bits [1:0] = 01, bit 2 = 0). It is shifted out bit 0 first.
- R4: The active instruction changes only on a rising edge in Update-IR, or in Test-Logic-Reset. Shifting a new code does not change the selected data path until Update-IR.
- R5: Active code 100 places the boundary chain between `tdi_i` and `tdo_o`. Code 101 (reserved) and every other code place the bypass stage there.
- R6: The bypass stage captures 0 on Capture-DR. In Shift-DR it delays `tdi_i` by exactly one clock.
- R7: On Capture-DR with code 100, chain bit i takes `pin_i[i]`, except that bits set in `NC_MASK` take 0 and bit `HIGH_BIT` takes 1. Bit 0 is shifted out first.
- R8: In Shift-DR with code 100, `tdi_i` enters at the top of the chain while the captured bits leave at the bottom. After `CHAIN_LEN` shifts, the preloaded bits emerge in the order they entered.
- R9: `tms_i` and `tdi_i` are sampled on the rising edge of `tck_i`. `tdo_o` changes only on the falling edge. `tdo_en_o` is high only for the falling-edge intervals that follow entry to Shift-DR or Shift-IR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low power-up reset |
| tms_i | input | 1 | Test mode select, sampled on rising edge |
| tdi_i | input | 1 | Serial test data in, sampled on rising edge |
| pin_i | input | CHAIN_LEN | I/O ring values observed by the boundary chain |
| tdo_o | output | 1 | Serial test data out, updated on falling edge |
| tdo_en_o | output | 1 | Output-driver enable for `tdo_o` (pad tri-states when low) |

## Verification
The bench builds the port with `CHAIN_LEN` = 12, `NC_MASK` = 12'h0C0 (bits 6 and 7 unconnected) and `HIGH_BIT` = 9. With these values a short chain can be scanned out twice in one pass. The forced-low and forced-high positions both sit among ordinary sampled bits, so pin patterns that drive those positions to the opposite value show whether the constants win. Bit 0 also differs between the bypass and sample paths, which makes path selection after reset, after the reserved code and after a mode-select reset visible at `tdo_o`.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  parameter int IR_W = 3;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_SAMPLE   = IR_W'(3'b100);
  localparam logic [IR_W-1:0] OP_RESERVED = IR_W'(3'b101);
  localparam logic [IR_W-1:0] OP_BYPASS   = {IR_W{1'b1}};
  localparam logic [IR_W-1:0] IR_CAPTURE  = {{(IR_W-2){1'b0}}, 2'b01};
endpackage

// File: rtl/bscan_fsm.sv
module bscan_fsm
  import bscan_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_TLR:    state_d = tms_i ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms_i ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms_i ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms_i ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms_i ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms_i ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms_i ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms_i ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms_i ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms_i ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_TLR;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // consecutive tms-high edge counter, saturating at 5
  logic [2:0] tms_run_q;
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                    tms_run_q <= '0;
    else if (!tms_i)                tms_run_q <= '0;
    else if (tms_run_q != 3'd5)     tms_run_q <= tms_run_q + 3'd1;
  end

  AST_FIVE_TMS_RESET: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (tms_run_q == 3'd5) |-> (state_q == ST_TLR)); // R1
endmodule

// File: rtl/bscan_ir.sv
module bscan_ir
  import bscan_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  tap_state_e      state_i,
  input  logic            tdi_i,
  output logic [IR_W-1:0] instr_o,
  output logic            so_o
);
  logic [IR_W-1:0] sr_q, instr_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= IR_CAPTURE;
    else if (state_i == ST_CAP_IR) sr_q <= IR_CAPTURE;
    else if (state_i == ST_SH_IR)  sr_q <= {tdi_i, sr_q[IR_W-1:1]};
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) instr_q <= OP_BYPASS;
    else if (state_i == ST_TLR)    instr_q <= OP_BYPASS;
    else if (state_i == ST_UPD_IR) instr_q <= sr_q;
  end

  assign instr_o = instr_q;
  assign so_o    = sr_q[0];

  AST_IR_CAPTURE_PATTERN: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_CAP_IR) |=> (sr_q[1:0] == 2'b01)); // R3
  AST_IR_HOLD: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !(state_i inside {ST_UPD_IR, ST_TLR}) |=> $stable(instr_q)); // R4
  AST_TLR_BYPASS: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_TLR) |=> (instr_q == OP_BYPASS)); // R1
endmodule

// File: rtl/bscan_bsr.sv
module bscan_bsr #(
  parameter int                  LEN      = 16,
  parameter logic [LEN-1:0]      NC_MASK  = '0,
  parameter int                  HIGH_BIT = 0
) (
  input  logic           tck_i,
  input  logic           rst_ni,
  input  logic           capture_i,
  input  logic           shift_i,
  input  logic           tdi_i,
  input  logic [LEN-1:0] pin_i,
  output logic           so_o
);
  logic [LEN-1:0] cap_val, sr_q;

  for (genvar i = 0; i < LEN; i++) begin : g_cell
    if (i == HIGH_BIT) begin : g_one
      assign cap_val[i] = 1'b1;
    end else if (NC_MASK[i]) begin : g_zero
      assign cap_val[i] = 1'b0;
    end else begin : g_pin
      assign cap_val[i] = pin_i[i];
    end
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)        sr_q <= '0;
    else if (capture_i) sr_q <= cap_val;
    else if (shift_i)   sr_q <= {tdi_i, sr_q[LEN-1:1]};
  end

  assign so_o = sr_q[0];

  AST_BSR_HIGH_BIT: assert property (@(posedge tck_i) disable iff (!rst_ni)
    capture_i |=> sr_q[HIGH_BIT]); // R7
  AST_BSR_NC_LOW: assert property (@(posedge tck_i) disable iff (!rst_ni)
    capture_i |=> ((sr_q & (NC_MASK & ~(LEN'(1) << HIGH_BIT))) == '0)); // R7
  AST_BSR_SHIFT_IN: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (shift_i && !capture_i) |=> (sr_q[LEN-1] == $past(tdi_i))); // R8
endmodule

// File: rtl/bscan_tap.sv
module bscan_tap
  import bscan_pkg::*;
#(
  parameter int                   CHAIN_LEN = 16,
  parameter logic [CHAIN_LEN-1:0] NC_MASK   = 16'h0300,
  parameter int                   HIGH_BIT  = 12
) (
  input  logic                 tck_i,
  input  logic                 rst_ni,
  input  logic                 tms_i,
  input  logic                 tdi_i,
  input  logic [CHAIN_LEN-1:0] pin_i,
  output logic                 tdo_o,
  output logic                 tdo_en_o
);
  tap_state_e      state;
  logic [IR_W-1:0] instr;
  logic            ir_so, bsr_so, sel_bsr, byp_q, dr_so, ser_out, in_shift;
  logic            tdo_q, tdo_en_q;

  bscan_fsm u_fsm (
    .tck_i  (tck_i),
    .rst_ni (rst_ni),
    .tms_i  (tms_i),
    .state_o(state)
  );

  bscan_ir u_ir (
    .tck_i  (tck_i),
    .rst_ni (rst_ni),
    .state_i(state),
    .tdi_i  (tdi_i),
    .instr_o(instr),
    .so_o   (ir_so)
  );

  assign sel_bsr = (instr == OP_SAMPLE);

  bscan_bsr #(
    .LEN     (CHAIN_LEN),
    .NC_MASK (NC_MASK),
    .HIGH_BIT(HIGH_BIT)
  ) u_bsr (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .capture_i(sel_bsr && state == ST_CAP_DR),
    .shift_i  (sel_bsr && state == ST_SH_DR),
    .tdi_i    (tdi_i),
    .pin_i    (pin_i),
    .so_o     (bsr_so)
  );

  // bypass stage: every code other than sample/preload
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                              byp_q <= 1'b0;
    else if (!sel_bsr && state == ST_CAP_DR)  byp_q <= 1'b0;
    else if (!sel_bsr && state == ST_SH_DR)   byp_q <= tdi_i;
  end

  assign dr_so    = sel_bsr ? bsr_so : byp_q;
  assign in_shift = (state == ST_SH_DR) || (state == ST_SH_IR);
  assign ser_out  = (state == ST_SH_IR) ? ir_so : dr_so;

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q    <= 1'b0;
      tdo_en_q <= 1'b0;
    end else begin
      tdo_q    <= in_shift ? ser_out : 1'b0;
      tdo_en_q <= in_shift;
    end
  end

  assign tdo_o    = tdo_q;
  assign tdo_en_o = tdo_en_q;

  AST_TDO_EN_SHIFT_ONLY: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_en_q |-> (state == ST_SH_DR || state == ST_SH_IR)); // R9
  AST_BYPASS_CAPTURE_ZERO: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (!sel_bsr && state == ST_CAP_DR) |=> !byp_q); // R6
  AST_RESERVED_IS_BYPASS: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (instr == OP_RESERVED) |-> !sel_bsr); // R5
endmodule

// File: tb/bscan_tap_bench.sv
module bscan_tap_bench;
  localparam int TCK_PERIOD = 10;
  localparam int N = 12;
  localparam logic [N-1:0] NC = 12'h0C0;
  localparam int HB = 9;

  logic tck = 1'b0, rst_ni = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic [N-1:0] pins = '0;
  logic tdo, tdo_en;
  logic obs, obs_en;
  int total = 0, bad = 0;

  always #(TCK_PERIOD/2) tck = ~tck;

  bscan_tap #(.CHAIN_LEN(N), .NC_MASK(NC), .HIGH_BIT(HB)) u_bscan_tap (
    .tck_i(tck), .rst_ni(rst_ni), .tms_i(tms), .tdi_i(tdi),
    .pin_i(pins), .tdo_o(tdo), .tdo_en_o(tdo_en)
  );

  localparam int NV = 4;
  localparam logic [N-1:0] VEC_PIN [NV] = '{12'hFFF, 12'h000, 12'hA5A, 12'h3C1};
  localparam logic [N-1:0] VEC_TDI [NV] = '{12'h000, 12'hFFF, 12'h5A5, 12'h9E3};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
    obs = tdo; obs_en = tdo_en;
  endtask

  task automatic ir_scan(input logic [2:0] op, output logic [2:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    cap[0] = obs;
    for (int k = 0; k < 3; k++) begin
      step(k == 2, op[k]);
      if (k < 2) cap[k+1] = obs;
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic dr_scan(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    dout[0] = obs;
    for (int k = 0; k < n; k++) begin
      step(k == n-1, din[k]);
      if (k < n-1) dout[k+1] = obs;
    end
    step(1, 0); step(0, 0);
  endtask

  function automatic logic [N-1:0] exp_cap(input logic [N-1:0] p);
    return (p & ~NC) | (N'(1) << HB);
  endfunction

  initial begin
    #(TCK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [2:0]  cap;
    logic [63:0] dout;
    #(TCK_PERIOD*2 + 3);
    chk("R2 tdo_en in reset", {63'b0, tdo_en}, 64'd0);
    rst_ni = 1'b1;
    step(0, 0);
    chk("R2 tdo_en idle", {63'b0, obs_en}, 64'd0);

    // power-up instruction is bypass: 0 then tdi delayed
    pins = 12'h001;
    dr_scan(4, 64'hB, dout);
    chk("R2 R6 bypass after reset", dout[3:0], 64'h6);

    ir_scan(3'b100, cap);
    chk("R3 capture-IR pattern", {61'b0, cap}, 64'h1);

    // table: capture then preload shift-through, 2N shifts
    for (int v = 0; v < NV; v++) begin
      pins = VEC_PIN[v];
      dr_scan(2*N, {40'b0, 12'h000, VEC_TDI[v]}, dout);
      chk("R7 capture", dout[N-1:0], exp_cap(VEC_PIN[v]));
      chk("R8 preload through", dout[2*N-1:N], VEC_TDI[v]);
    end

    // reserved code behaves as bypass
    ir_scan(3'b101, cap);
    chk("R3 capture-IR after sample", {61'b0, cap}, 64'h1);
    pins = 12'h001;
    dr_scan(4, 64'h5, dout);
    chk("R5 reserved is bypass", dout[3:0], 64'hA);

    // R4 R5: update then sample path is live
    ir_scan(3'b100, cap);
    dr_scan(N, 64'h0, dout);
    chk("R4 R5 sample selected after update", dout[N-1:0], exp_cap(12'h001));

    // R9: edge discipline in bypass shift
    ir_scan(3'b111, cap);
    step(1, 0); step(0, 0); step(0, 0);
    chk("R9 en in shift", {63'b0, obs_en}, 64'd1);
    chk("R6 bypass captured zero", {63'b0, obs}, 64'd0);
    tms = 0; tdi = 1;
    @(posedge tck); #1;
    chk("R9 tdo holds at rising edge", {63'b0, tdo}, 64'd0);
    @(negedge tck); #1;
    chk("R9 R6 tdo at falling edge", {63'b0, tdo}, 64'd1);

    // R1: five tms-high from shift-DR with sample loaded
    ir_scan(3'b100, cap);
    step(1, 0); step(0, 0); step(0, 0);
    for (int k = 0; k < 5; k++) step(1, 0);
    chk("R1 tdo_en off after tms reset", {63'b0, obs_en}, 64'd0);
    step(0, 0);
    pins = 12'h001;
    dr_scan(4, 64'h3, dout);
    chk("R1 bypass after tms reset", dout[3:0], 64'h6);

    // R1 from shift-IR mid-scan
    step(1, 0); step(1, 0); step(0, 0); step(0, 0); step(0, 0);
    for (int k = 0; k < 5; k++) step(1, 1);
    step(0, 0);
    dr_scan(2, 64'h1, dout);
    chk("R1 bypass after IR-state reset", dout[1:0], 64'h2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule